// File: doc/BRIEF.md
# Warm Reset Sequencer with Pre-Reset Handshakes

This block takes a warm reset request from software, from an external reset pin, from fabric logic or from one of four watchdogs. It then asks up to five client blocks to prepare for the reset, one at a time. The clients are an SDRAM controller that must enter self-refresh, a configuration-manager clock, a scan-manager clock, fabric soft logic, and a trace AXI master that must go idle. Each client has its own enable bit and its own timeout. After the handshakes the block asserts the clock-control reset and the general warm reset together. It drives the external reset pin low for a programmed number of cycles. It releases the clock-control reset first and the general warm reset a programmed number of cycles later.

Every request source and every handshake timeout sets a sticky bit in a status word. Software clears these bits with a write mask. Configuration and status sit behind a small valid/ready register port with four word addresses.

Top module: `warm_rst_seq`

## Requirements
- R1: The handshake requests on `hs_req` run in index order: 0 SDRAM self-refresh, 1 configuration manager, 2 scan manager, 3 fabric, 4 trace idle. Only those whose enable bit is set in bits [4:0] of the control word (address 0) run; the others are skipped.
- R2: At most one `hs_req` bit is high at any time. No `hs_req` bit is high while `clkctl_rst` or `warm_rst` is high, so self-refresh completes before any reset output asserts.
- R3: A handshake whose `hs_ack` bit stays low keeps its request high for exactly 1024 cycles. The block then sets status bit 24+index and carries on with the sequence.
- R4: `ext_rst_drive` is high for exactly W consecutive cycles in each sequence, where W is the 20-bit value at address 2. W = 0 leaves it low.
- R5: `clkctl_rst` and `warm_rst` rise together. `clkctl_rst` falls first, and `warm_rst` falls exactly D cycles after it, where D is the value at address 1.
- R6: A write to address 1 stores the value clamped to the range 17..255.
- R7: Each request source sets its own status bit (address 3): pin at bit 8, fabric at bit 9, software at bit 10, and watchdog i at bit 12+i. A software request is a write to address 0 with bit 8 set.
- R8: Status bits stay set until a write to address 3 that has a 1 in their position. Bits written 0 are unchanged.
- R9: A request that arrives while a sequence runs sets its status bit but starts no second sequence. Writes to address 1 during a sequence are ignored.
- R10: After reset all outputs are low except `reg_ready`. The control word reads 0, the delay reads 32, the width reads 16 and the status reads 0.
- R11: A read accepted in one cycle returns its data with `reg_rvalid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word address: 0 control, 1 delay, 2 pin width, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| pin_warm_req | input | 1 | External pin reset request, active high, synchronized |
| fabric_warm_req | input | 1 | Fabric warm reset request |
| wdog_warm_req | input | 4 | Watchdog requests: 0/1 processor, 2/3 peripheral |
| hs_req | output | 5 | Handshake requests, index order as in R1 |
| hs_ack | input | 5 | Handshake acknowledges |
| clkctl_rst | output | 1 | Clock-control reset, active high |
| warm_rst | output | 1 | Warm reset to the other blocks, active high |
| ext_rst_drive | output | 1 | High pulls the external reset pin low |

## Verification
A software request starts the sequence one cycle after the control write. A pin, fabric or watchdog edge sets its status bit at the same clock edge at which it is sampled. Read data arrives one cycle after the access. Handshake order, request lengths, pin width and release gap do not fall at fixed cycles. They depend on acknowledge timing and on the programmed values. The bench therefore does not wait fixed counts for them. A falling-edge monitor counts the cycles in which each output is high and logs the index of each rising request. Each test waits for the falling edge of `warm_rst` and then compares these counts with the programmed W, D and 1024.

// File: rtl/wrs_pkg.sv
// Package: shared constants, status bit positions and helpers for the
// warm reset sequencer. Assumes a 32-bit register data path.
package wrs_pkg;
    localparam int DLY_W   = 8;
    localparam int DLY_MIN = 17;
    localparam int DLY_MAX = 255;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_DELAY  = 2'd1;
    localparam logic [1:0] A_WIDTH  = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;

    localparam int CTRL_SW_BIT = 8;
    localparam int ST_PIN  = 8;
    localparam int ST_FAB  = 9;
    localparam int ST_SW   = 10;
    localparam int ST_WD0  = 12;
    localparam int ST_TMO0 = 24;

    typedef enum logic [1:0] {REL_IDLE, REL_HOLD, REL_STAGE} rel_state_t;

    // Clamp a written delay into the legal staged-release range.
    function automatic logic [DLY_W-1:0] clamp_delay(input logic [31:0] v);
        if (v < 32'(DLY_MIN)) return DLY_W'(DLY_MIN);
        if (v > 32'(DLY_MAX)) return DLY_W'(DLY_MAX);
        return v[DLY_W-1:0];
    endfunction
endpackage

// File: rtl/wrs_regs.sv
// Module: register file and sticky status word of the warm reset sequencer.
// Assumes one access per cycle, always accepted; reads return next cycle.
// Delay writes are dropped while a sequence is busy.
module wrs_regs
    import wrs_pkg::*;
#(
    parameter int NUM_HS  = 5,
    parameter int NUM_WD  = 4,
    parameter int PW_W    = 20,
    parameter int DLY_RST = 32,
    parameter int PW_RST  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              pin_evt,
    input  logic              fab_evt,
    input  logic [NUM_WD-1:0] wd_evt,
    input  logic [NUM_HS-1:0] tmo_evt,
    output logic [NUM_HS-1:0] hs_en,
    output logic [DLY_W-1:0]  dly,
    output logic [PW_W-1:0]   pw,
    output logic              sw_req
);
    logic [NUM_HS-1:0] en_q;
    logic [DLY_W-1:0]  dly_q;
    logic [PW_W-1:0]   pw_q;
    logic [31:0]       st_q, set_vec, clr_vec;
    logic              sw_q, rv_q;
    logic [31:0]       rd_q;
    logic              wr, rd, clr_we;

    assign wr     = bus_valid & bus_write;
    assign rd     = bus_valid & ~bus_write;
    assign clr_we = wr && (bus_addr == A_STATUS);

    // Collect the status bits to be set this cycle.
    always_comb begin
        set_vec = '0;
        set_vec[ST_PIN] = pin_evt;
        set_vec[ST_FAB] = fab_evt;
        set_vec[ST_SW]  = sw_q;
        for (int i = 0; i < NUM_WD; i++) set_vec[ST_WD0 + i]  = wd_evt[i];
        for (int i = 0; i < NUM_HS; i++) set_vec[ST_TMO0 + i] = tmo_evt[i];
    end

    assign clr_vec = clr_we ? bus_wdata : '0;

    // Configuration registers and the one-cycle software request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dly_q <= DLY_W'(DLY_RST);
            pw_q  <= PW_W'(PW_RST);
            sw_q  <= 1'b0;
        end else begin
            sw_q <= wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_SW_BIT];
            if (wr && bus_addr == A_CTRL)             en_q  <= bus_wdata[NUM_HS-1:0];
            if (wr && bus_addr == A_DELAY && !busy)  dly_q <= clamp_delay(bus_wdata);
            if (wr && bus_addr == A_WIDTH)            pw_q  <= bus_wdata[PW_W-1:0];
        end
    end

    // Sticky status: setting wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_vec) | set_vec;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
            rd_q <= '0;
        end else begin
            rv_q <= rd;
            if (rd) begin
                case (bus_addr)
                    A_CTRL:  rd_q <= 32'(en_q);
                    A_DELAY: rd_q <= 32'(dly_q);
                    A_WIDTH: rd_q <= 32'(pw_q);
                    default: rd_q <= st_q;
                endcase
            end
        end
    end

    assign hs_en      = en_q;
    assign dly        = dly_q;
    assign pw         = pw_q;
    assign sw_req     = sw_q;
    assign bus_rvalid = rv_q;
    assign bus_rdata  = rd_q;

    // R6: stored delay never below the legal minimum
    a_r6_delay_min: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q >= DLY_W'(DLY_MIN));
    // R8: without a clear write no status bit drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: rtl/wrs_hs_chain.sv
// Module: walks the enabled pre-reset handshakes lowest index first, one at
// a time. Each waits for its acknowledge or a shared timeout; a timeout
// yields a one-cycle event on its index. Assumes start only when idle.
module wrs_hs_chain #(
    parameter int NUM_HS = 5,
    parameter int TMO    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_HS-1:0] en,
    input  logic [NUM_HS-1:0] ack,
    output logic [NUM_HS-1:0] req,
    output logic [NUM_HS-1:0] tmo_evt,
    output logic              done,
    output logic              active
);
    localparam int TW = $clog2(TMO + 1);

    logic [NUM_HS-1:0] pend_q, cur;
    logic [TW-1:0]     tmr_q;
    logic              act_q, hit, expire;

    assign cur     = pend_q & (~pend_q + NUM_HS'(1));
    assign hit     = |(cur & ack);
    assign expire  = (tmr_q == TW'(TMO - 1));
    assign req     = act_q ? cur : '0;
    assign done    = act_q && (pend_q == '0);
    assign tmo_evt = (act_q && !hit && expire) ? cur : '0;
    assign active  = act_q;

    // Pending mask, activity flag and per-handshake wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= 1'b0;
            tmr_q  <= '0;
        end else if (start) begin
            pend_q <= en;
            act_q  <= 1'b1;
            tmr_q  <= '0;
        end else if (act_q) begin
            if (pend_q == '0) begin
                act_q <= 1'b0;
            end else if (hit || expire) begin
                pend_q <= pend_q & ~cur;
                tmr_q  <= '0;
            end else begin
                tmr_q <= tmr_q + TW'(1);
            end
        end
    end

    // R2: never two handshake requests at once
    a_r2_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    // R3: wait timer stays inside the timeout window
    a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (tmr_q < TW'(TMO)));
    // R9: no restart while a chain is running
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !act_q);
    // R1: once running, no handshake is added back
    a_r1_no_readd: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !start) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/wrs_release.sv
// Module: drives the reset outputs. It asserts both resets and the pin
// pulse, holds for the pulse width (one cycle if zero), releases the
// clock-control reset, then counts the staged delay before releasing the
// warm reset. Width and delay are captured at start.
module wrs_release
    import wrs_pkg::*;
#(
    parameter int PW_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PW_W-1:0]  pw,
    input  logic [DLY_W-1:0] dly,
    output logic             clkctl_rst,
    output logic             warm_rst,
    output logic             pin_drive,
    output logic             active
);
    localparam int CW = (PW_W > DLY_W) ? PW_W : DLY_W;

    rel_state_t       st_q;
    logic [PW_W-1:0]  pw_q;
    logic [DLY_W-1:0] dly_q;
    logic [CW-1:0]    cnt_q, cnt_nx;
    logic             clk_q, warm_q, pin_q;

    assign cnt_nx = cnt_q + CW'(1);

    // Hold / staged release state machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= REL_IDLE;
            pw_q   <= '0;
            dly_q  <= '0;
            cnt_q  <= '0;
            clk_q  <= 1'b0;
            warm_q <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            case (st_q)
                REL_IDLE: if (start) begin
                    st_q   <= REL_HOLD;
                    pw_q   <= pw;
                    dly_q  <= dly;
                    cnt_q  <= '0;
                    clk_q  <= 1'b1;
                    warm_q <= 1'b1;
                    pin_q  <= (pw != '0);
                end
                REL_HOLD: begin
                    if (pw_q == '0 || cnt_nx == CW'(pw_q)) begin
                        pin_q <= 1'b0;
                        clk_q <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= REL_STAGE;
                    end else begin
                        cnt_q <= cnt_nx;
                    end
                end
                REL_STAGE: begin
                    if (cnt_nx == CW'(dly_q)) begin
                        warm_q <= 1'b0;
                        st_q   <= REL_IDLE;
                    end else begin
                        cnt_q <= cnt_nx;
                    end
                end
                default: st_q <= REL_IDLE;
            endcase
        end
    end

    assign clkctl_rst = clk_q;
    assign warm_rst   = warm_q;
    assign pin_drive  = pin_q;
    assign active     = (st_q != REL_IDLE);

    // R5: warm reset falls only out of the staged phase, clock reset already low
    a_r5_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_q) |-> (!clk_q && $past(st_q) == REL_STAGE));
    // R4: the pin pulse lies inside the reset hold
    a_r4_pin_inside: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q |-> (clk_q && warm_q));
endmodule

// File: rtl/warm_rst_seq.sv
// Module: top of the warm reset sequencer. It edge-detects the request
// inputs, starts a sequence only when idle, chains the handshakes into the
// release unit and feeds events to the status word. Assumes request inputs
// are already synchronous to clk.
module warm_rst_seq
    import wrs_pkg::*;
#(
    parameter int NUM_HS  = 5,
    parameter int NUM_WD  = 4,
    parameter int PW_W    = 20,
    parameter int HS_TMO  = 1024,
    parameter int DLY_RST = 32,
    parameter int PW_RST  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic              reg_write,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata,
    input  logic              pin_warm_req,
    input  logic              fabric_warm_req,
    input  logic [NUM_WD-1:0] wdog_warm_req,
    output logic [NUM_HS-1:0] hs_req,
    input  logic [NUM_HS-1:0] hs_ack,
    output logic              clkctl_rst,
    output logic              warm_rst,
    output logic              ext_rst_drive
);
    logic              pin_prev, fab_prev;
    logic [NUM_WD-1:0] wd_prev, wd_evt;
    logic              pin_evt, fab_evt, sw_req, any_req, busy, seq_start;
    logic [NUM_HS-1:0] hs_en, tmo_evt;
    logic [DLY_W-1:0]  dly;
    logic [PW_W-1:0]   pw;
    logic              hs_done, hs_active, rel_active;

    // Previous request levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
            fab_prev <= 1'b0;
            wd_prev  <= '0;
        end else begin
            pin_prev <= pin_warm_req;
            fab_prev <= fabric_warm_req;
            wd_prev  <= wdog_warm_req;
        end
    end

    assign pin_evt = pin_warm_req & ~pin_prev;
    assign fab_evt = fabric_warm_req & ~fab_prev;

    genvar g;
    generate
        for (g = 0; g < NUM_WD; g++) begin : g_wd_edge
            assign wd_evt[g] = wdog_warm_req[g] & ~wd_prev[g];
        end
    endgenerate

    assign any_req   = pin_evt | fab_evt | (|wd_evt) | sw_req;
    assign busy      = hs_active | rel_active;
    assign seq_start = any_req & ~busy;
    assign reg_ready = 1'b1;

    wrs_regs #(
        .NUM_HS(NUM_HS), .NUM_WD(NUM_WD), .PW_W(PW_W),
        .DLY_RST(DLY_RST), .PW_RST(PW_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(reg_valid), .bus_write(reg_write), .bus_addr(reg_addr),
        .bus_wdata(reg_wdata), .bus_rvalid(reg_rvalid), .bus_rdata(reg_rdata),
        .busy(busy), .pin_evt(pin_evt), .fab_evt(fab_evt), .wd_evt(wd_evt),
        .tmo_evt(tmo_evt), .hs_en(hs_en), .dly(dly), .pw(pw), .sw_req(sw_req)
    );

    wrs_hs_chain #(.NUM_HS(NUM_HS), .TMO(HS_TMO)) u_chain (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .en(hs_en), .ack(hs_ack),
        .req(hs_req), .tmo_evt(tmo_evt), .done(hs_done), .active(hs_active)
    );

    wrs_release #(.PW_W(PW_W)) u_rel (
        .clk(clk), .rst_n(rst_n), .start(hs_done), .pw(pw), .dly(dly),
        .clkctl_rst(clkctl_rst), .warm_rst(warm_rst), .pin_drive(ext_rst_drive),
        .active(rel_active)
    );

    // R2: no handshake request while either reset output is asserted
    a_r2_hs_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_req) |-> (!warm_rst && !clkctl_rst));
    // R5: the clock-control reset is never high without the warm reset
    a_r5_clk_within_warm: assert property (@(posedge clk) disable iff (!rst_n)
        clkctl_rst |-> warm_rst);
endmodule

// File: tb/warm_rst_seq_tb.sv
module warm_rst_seq_tb;
    localparam int NHS = 5;
    localparam int TMO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ready, reg_rvalid;
    logic [31:0] reg_rdata;
    logic        pin_warm_req = 1'b0, fabric_warm_req = 1'b0;
    logic [3:0]  wdog_warm_req = '0;
    logic [NHS-1:0] hs_req, hs_ack = '0;
    logic        clkctl_rst, warm_rst, ext_rst_drive;

    always #2.5 clk = ~clk;

    warm_rst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .pin_warm_req(pin_warm_req), .fabric_warm_req(fabric_warm_req),
        .wdog_warm_req(wdog_warm_req), .hs_req(hs_req), .hs_ack(hs_ack),
        .clkctl_rst(clkctl_rst), .warm_rst(warm_rst), .ext_rst_drive(ext_rst_drive)
    );

    int checks = 0, errors = 0;
    bit reported = 0;

    // Monitor state (falling-edge sampling).
    logic [NHS-1:0] withhold = '0;
    logic [NHS-1:0] prev_req = '0;
    logic prev_warm = 1'b0;
    int log_q[8];
    int log_n = 0;
    int reqlen[NHS];
    int pinw = 0, gap = 0, last_pin = 0, last_gap = 0, seq_cnt = 0, overlap = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // Log handshake order and durations, measure pin and release timing, answer acks.
    always @(negedge clk) begin
        for (int i = 0; i < NHS; i++) begin
            if (hs_req[i] && !prev_req[i]) begin
                if (log_n < 8) log_q[log_n] = i;
                log_n++;
            end
            if (hs_req[i]) reqlen[i]++;
        end
        prev_req = hs_req;
        if ((|hs_req) && (warm_rst || clkctl_rst)) overlap++;
        if (warm_rst && !prev_warm) begin pinw = 0; gap = 0; end
        if (ext_rst_drive) pinw++;
        if (!clkctl_rst && warm_rst) gap++;
        if (!warm_rst && prev_warm) begin
            seq_cnt++;
            last_pin = pinw;
            last_gap = gap;
        end
        prev_warm = warm_rst;
        hs_ack = hs_req & ~withhold;
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d, input string tag);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        chk(reg_rvalid === 1'b1, tag, "R11 rvalid one cycle after read", 32'(reg_rvalid), 1);
        d = reg_rdata;
    endtask

    task automatic clear_log();
        log_n = 0;
        for (int i = 0; i < NHS; i++) reqlen[i] = 0;
    endtask

    task automatic wait_done(input int start_cnt, input string tag);
        int n = 0;
        while (seq_cnt == start_cnt && n < 8000) begin
            @(negedge clk);
            n++;
        end
        chk(seq_cnt == start_cnt + 1, tag, "sequence completes", 32'(seq_cnt), 32'(start_cnt + 1));
    endtask

    task automatic clear_status();
        bus_write(2'd3, 32'hFFFF_FFFF);
    endtask

    // R10: reset values of outputs and registers.
    task automatic t_reset();
        logic [31:0] v;
        chk(!clkctl_rst && !warm_rst && !ext_rst_drive && hs_req == 0, "R10",
            "outputs low", {clkctl_rst, warm_rst, ext_rst_drive, 24'd0, hs_req}, 0);
        chk(reg_ready === 1'b1, "R10", "ready high", 32'(reg_ready), 1);
        bus_read(2'd0, v, "R10"); chk(v == 0,  "R10", "control", v, 0);
        bus_read(2'd1, v, "R10"); chk(v == 32, "R10", "delay",   v, 32);
        bus_read(2'd2, v, "R10"); chk(v == 16, "R10", "width",   v, 16);
        bus_read(2'd3, v, "R10"); chk(v == 0,  "R10", "status",  v, 0);
    endtask

    // R6: delay clamping.
    task automatic t_clamp();
        logic [31:0] v;
        bus_write(2'd1, 5);    bus_read(2'd1, v, "R6"); chk(v == 17,  "R6", "low clamp", v, 17);
        bus_write(2'd1, 1000); bus_read(2'd1, v, "R6"); chk(v == 255, "R6", "high clamp", v, 255);
        bus_write(2'd1, 40);   bus_read(2'd1, v, "R6"); chk(v == 40,  "R6", "in range", v, 40);
    endtask

    // R1 R2: order for every enable combination.
    task automatic t_order();
        bus_write(2'd1, 17);
        bus_write(2'd2, 3);
        withhold = '0;
        for (int m = 0; m < 32; m++) begin
            int base = seq_cnt;
            int k = 0;
            bit ok = 1;
            clear_log();
            bus_write(2'd0, 32'h100 | 32'(m));
            wait_done(base, "R1");
            for (int i = 0; i < NHS; i++) begin
                if (m[i]) begin
                    if (k >= log_n || log_q[k] != i) ok = 0;
                    k++;
                end
            end
            chk(ok && log_n == k, "R1", $sformatf("order for enables %0h", m), 32'(log_n), 32'(k));
            chk(last_pin == 3 && last_gap == 17, "R1", "timing in order run",
                32'(last_pin * 256 + last_gap), 32'(3 * 256 + 17));
        end
        chk(overlap == 0, "R2", "no request during reset", 32'(overlap), 0);
        clear_status();
    endtask

    // R3: each withheld acknowledge times out.
    task automatic t_timeout();
        logic [31:0] v;
        for (int k = 0; k < NHS; k++) begin
            int base = seq_cnt;
            clear_log();
            withhold = NHS'(1) << k;
            bus_write(2'd0, 32'h11F);
            wait_done(base, "R3");
            chk(reqlen[k] == TMO, "R3", $sformatf("request %0d length", k), 32'(reqlen[k]), TMO);
            chk(log_n == NHS, "R3", "chain continued", 32'(log_n), NHS);
            bus_read(2'd3, v, "R3");
            chk(v == ((32'h1 << 10) | (32'h1 << (24 + k))), "R3",
                $sformatf("timeout bit %0d", k), v, (32'h1 << 10) | (32'h1 << (24 + k)));
            clear_status();
        end
        withhold = '0;
    endtask

    // R4: exact pin pulse width, including zero.
    task automatic t_pin();
        int ws[3] = '{0, 1, 37};
        bus_write(2'd0, 0);
        for (int j = 0; j < 3; j++) begin
            int base = seq_cnt;
            bus_write(2'd2, 32'(ws[j]));
            bus_write(2'd0, 32'h100);
            wait_done(base, "R4");
            chk(last_pin == ws[j], "R4", "pin width", 32'(last_pin), 32'(ws[j]));
        end
        clear_status();
    endtask

    // R5: staged release gap.
    task automatic t_release();
        int ds[3] = '{17, 255, 100};
        bus_write(2'd2, 2);
        for (int j = 0; j < 3; j++) begin
            int base = seq_cnt;
            bus_write(2'd1, 32'(ds[j]));
            bus_write(2'd0, 32'h100);
            wait_done(base, "R5");
            chk(last_gap == ds[j], "R5", "release gap", 32'(last_gap), 32'(ds[j]));
        end
        clear_status();
    endtask

    // R7: each cause sets its own bit.
    task automatic t_causes();
        logic [31:0] v;
        for (int s = 0; s < 6; s++) begin
            int base = seq_cnt;
            logic [31:0] exp;
            @(negedge clk);
            case (s)
                0: begin pin_warm_req = 1'b1;    exp = 32'h1 << 8; end
                1: begin fabric_warm_req = 1'b1; exp = 32'h1 << 9; end
                default: begin wdog_warm_req[s-2] = 1'b1; exp = 32'h1 << (12 + s - 2); end
            endcase
            @(negedge clk);
            pin_warm_req = 1'b0; fabric_warm_req = 1'b0; wdog_warm_req = '0;
            wait_done(base, "R7");
            bus_read(2'd3, v, "R7");
            chk(v == exp, "R7", $sformatf("cause %0d bit", s), v, exp);
            clear_status();
        end
    endtask

    // R9 R8: request and delay write during a sequence, then masked clear.
    task automatic t_busy();
        logic [31:0] v;
        int base;
        bus_write(2'd1, 40);
        bus_write(2'd2, 300);
        base = seq_cnt;
        bus_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        bus_write(2'd1, 200);
        @(negedge clk); fabric_warm_req = 1'b1;
        @(negedge clk); fabric_warm_req = 1'b0;
        wait_done(base, "R9");
        repeat (30) @(negedge clk);
        chk(seq_cnt == base + 1 && !warm_rst, "R9", "no second sequence", 32'(seq_cnt), 32'(base + 1));
        chk(last_gap == 40, "R9", "old delay used", 32'(last_gap), 40);
        bus_read(2'd1, v, "R9"); chk(v == 40, "R9", "delay write ignored", v, 40);
        bus_read(2'd3, v, "R9");
        chk(v == 32'h0000_0600, "R9", "late request recorded", v, 32'h600);
        bus_write(2'd3, 32'h0000_0200);
        bus_read(2'd3, v, "R8"); chk(v == 32'h0000_0400, "R8", "masked clear", v, 32'h400);
        bus_write(2'd3, 32'h0000_0000);
        bus_read(2'd3, v, "R8"); chk(v == 32'h0000_0400, "R8", "zero mask keeps", v, 32'h400);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_order();
        t_timeout();
        t_pin();
        t_release();
        t_causes();
        t_busy();
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule